// File: doc/BRIEF.md
# Parallel Add-Subtract Unit with Saturation

This unit takes two 32-bit operands and returns their sum and their difference (a minus b) together, from a single operation. The sum comes out on one result word and the difference on the other. It works either on full 32-bit words or in a split mode, where each word holds two independent 16-bit lanes. In split mode each lane gives its own sum and difference, and those results stay in the bit positions of their lane.

A per-operation control bit chooses between wrapping (modulo) arithmetic and signed saturating arithmetic. In saturating mode, any result that overflows is clamped to the signed limit of its lane. A sticky flag records that a clamp has happened since the flag was last cleared, and a dedicated input clears it.

The unit accepts a new operation on every clock. Both result words and the flag are registered, so each result appears one cycle after its operands are presented.

Top module: `par_addsub`

## Requirements
- R1: The operands sampled at a rising clock edge produce `sum_o` = a + b and `diff_o` = a − b. Both are visible after that edge and hold until the next edge.
- R2: With `split_i`=0 and `sat_i`=0, both results are computed on the full 32-bit word and wrap modulo 2^32. This includes a carry or borrow out of bit 15 into bit 16.
- R3: With `split_i`=1 and `sat_i`=0, lane 0 occupies bits 15:0 and lane 1 occupies bits 31:16. Each lane computes its own sum and difference modulo 2^16, and no carry or borrow crosses between the lanes.
- R4: With `split_i`=0 and `sat_i`=1, a signed two's-complement result above 0x7FFFFFFF becomes 0x7FFFFFFF, and one below 0x80000000 becomes 0x80000000.
- R5: With `split_i`=1 and `sat_i`=1, each lane's signed result is clamped to the range 0x8000 to 0x7FFF on its own. A lane that does not overflow keeps its exact value.
- R6: `sat_flag_o` rises at the same edge that registers a result in which any lane (sum or difference) was clamped. It then stays high. No overflow sets it while `sat_i`=0.
- R7: When `clr_sat_i`=1 at an edge, `sat_flag_o` goes low after that edge. If a clamp occurs at that same edge, the flag stays high.
- R8: While `rst_ni`=0, `sum_o`, `diff_o` and `sat_flag_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (subtrahend) |
| split_i | input | 1 | 1 = two 16-bit lanes, 0 = one 32-bit word |
| sat_i | input | 1 | 1 = saturating, 0 = wrapping |
| clr_sat_i | input | 1 | Clears the sticky saturation flag |
| sum_o | output | 32 | Registered sum |
| diff_o | output | 32 | Registered difference a − b |
| sat_flag_o | output | 1 | Sticky flag: a clamp has occurred |

## Verification
Two events can land on the same edge: a clear request and a new clamp. The bench builds this case deliberately. First it saturates once to set the flag. Then it presents an overflowing saturating operation with `clr_sat_i` held high, and expects the flag to remain set. It also presents a clear with a non-overflowing operation, and expects the flag to drop. Operand sweeps over lane corner values (0, ±1, the limits and their neighbours), in every mode, compare both result words with an arithmetic model on each cycle.

// File: rtl/par_addsub_pkg.sv
package par_addsub_pkg;
  localparam int unsigned LANE_W_DEF    = 16;
  localparam int unsigned NUM_LANES_DEF = 2;

  typedef enum logic {
    MODE_FULL  = 1'b0,
    MODE_SPLIT = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/addsub_lane.sv
module addsub_lane #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sat_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] diff_o,
  output logic         clamp_o
);
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] raw_sum, raw_diff;
  logic         ovf_sum, ovf_diff;

  assign raw_sum  = a_i + b_i;
  assign raw_diff = a_i - b_i;
  // signed overflow: operand signs agree (add) / differ (sub) and result sign flips
  assign ovf_sum  = (a_i[W-1] == b_i[W-1]) && (raw_sum[W-1]  != a_i[W-1]);
  assign ovf_diff = (a_i[W-1] != b_i[W-1]) && (raw_diff[W-1] != a_i[W-1]);

  always_comb begin
    sum_o  = raw_sum;
    diff_o = raw_diff;
    if (sat_i && ovf_sum)  sum_o  = a_i[W-1] ? MIN_V : MAX_V;
    if (sat_i && ovf_diff) diff_o = a_i[W-1] ? MIN_V : MAX_V;
  end

  assign clamp_o = sat_i && (ovf_sum || ovf_diff);
endmodule

// File: rtl/par_addsub.sv
module par_addsub
  import par_addsub_pkg::*;
#(
  parameter int unsigned LANE_W    = LANE_W_DEF,
  parameter int unsigned NUM_LANES = NUM_LANES_DEF
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [LANE_W*NUM_LANES-1:0] a_i,
  input  logic [LANE_W*NUM_LANES-1:0] b_i,
  input  logic                        split_i,
  input  logic                        sat_i,
  input  logic                        clr_sat_i,
  output logic [LANE_W*NUM_LANES-1:0] sum_o,
  output logic [LANE_W*NUM_LANES-1:0] diff_o,
  output logic                        sat_flag_o
);
  localparam int unsigned WORD_W = LANE_W * NUM_LANES;

  lane_mode_e mode;
  assign mode = lane_mode_e'(split_i);

  logic [WORD_W-1:0]    full_sum, full_diff, lane_sum, lane_diff;
  logic                 full_clamp;
  logic [NUM_LANES-1:0] lane_clamp;

  addsub_lane #(.W(WORD_W)) u_full (
    .a_i(a_i), .b_i(b_i), .sat_i(sat_i),
    .sum_o(full_sum), .diff_o(full_diff), .clamp_o(full_clamp)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    addsub_lane #(.W(LANE_W)) u_lane (
      .a_i    (a_i[g*LANE_W +: LANE_W]),
      .b_i    (b_i[g*LANE_W +: LANE_W]),
      .sat_i  (sat_i),
      .sum_o  (lane_sum[g*LANE_W +: LANE_W]),
      .diff_o (lane_diff[g*LANE_W +: LANE_W]),
      .clamp_o(lane_clamp[g])
    );
  end

  logic [WORD_W-1:0] sum_d, diff_d;
  logic              clamp_d;

  always_comb begin
    if (mode == MODE_SPLIT) begin
      sum_d   = lane_sum;
      diff_d  = lane_diff;
      clamp_d = |lane_clamp;
    end else begin
      sum_d   = full_sum;
      diff_d  = full_diff;
      clamp_d = full_clamp;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o      <= '0;
      diff_o     <= '0;
      sat_flag_o <= 1'b0;
    end else begin
      sum_o      <= sum_d;
      diff_o     <= diff_d;
      // new clamp wins over a same-cycle clear
      sat_flag_o <= (sat_flag_o && !clr_sat_i) || clamp_d;
    end
  end

  AST_FULL_WRAP_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!split_i && !sat_i) |=> sum_o == $past(WORD_W'(a_i + b_i)));  // R2
  AST_FULL_WRAP_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!split_i && !sat_i) |=> diff_o == $past(WORD_W'(a_i - b_i)));  // R1
  AST_LANE_ISOLATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split_i && !sat_i) |=> sum_o[LANE_W-1:0] ==
      $past(LANE_W'(a_i[LANE_W-1:0] + b_i[LANE_W-1:0])));  // R3
  AST_FULL_SAT_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!split_i && sat_i && (a_i[WORD_W-1] == b_i[WORD_W-1])) |=>
      sum_o[WORD_W-1] == $past(a_i[WORD_W-1]));  // R4
  AST_LANE_SAT_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split_i && sat_i && (a_i[LANE_W-1] == b_i[LANE_W-1])) |=>
      sum_o[LANE_W-1] == $past(a_i[LANE_W-1]));  // R5
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_flag_o && !clr_sat_i) |=> sat_flag_o);  // R6
  AST_FLAG_NO_WRAP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sat_flag_o && !sat_i) |=> !sat_flag_o);  // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_sat_i && !sat_i) |=> !sat_flag_o);  // R7
endmodule

// File: tb/par_addsub_tb.sv
module par_addsub_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        split = 1'b0, sat = 1'b0, clr = 1'b0;
  logic [31:0] sum, diff;
  logic        flag;

  int checks = 0;
  int errors = 0;
  bit exp_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_addsub u_dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b),
    .split_i(split), .sat_i(sat), .clr_sat_i(clr),
    .sum_o(sum), .diff_o(diff), .sat_flag_o(flag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic longint sext(input logic [31:0] v, input int w);
    longint r;
    r = longint'(v) & ((longint'(1) <<< w) - 1);
    if (r[w-1]) r = r - (longint'(1) <<< w);
    return r;
  endfunction

  // one lane: returns {sum,diff} in low bits, sets clamp
  task automatic lane_ref(input logic [31:0] x, input logic [31:0] y, input int w,
                          input bit s, output logic [31:0] rs, output logic [31:0] rd,
                          output bit c);
    longint mx, mn, vs, vd, mask;
    mx = (longint'(1) <<< (w-1)) - 1;
    mn = -(longint'(1) <<< (w-1));
    mask = (longint'(1) <<< w) - 1;
    vs = sext(x, w) + sext(y, w);
    vd = sext(x, w) - sext(y, w);
    c = 1'b0;
    if (s && vs > mx) begin vs = mx; c = 1'b1; end
    if (s && vs < mn) begin vs = mn; c = 1'b1; end
    if (s && vd > mx) begin vd = mx; c = 1'b1; end
    if (s && vd < mn) begin vd = mn; c = 1'b1; end
    rs = 32'(vs & mask);
    rd = 32'(vd & mask);
  endtask

  task automatic model(input logic [31:0] x, input logic [31:0] y, input bit sp,
                       input bit s, output logic [31:0] es, output logic [31:0] ed,
                       output bit c);
    logic [31:0] s0, d0, s1, d1;
    bit c0, c1;
    if (sp) begin
      lane_ref(x, y, 16, s, s0, d0, c0);
      lane_ref(x >> 16, y >> 16, 16, s, s1, d1, c1);
      es = {s1[15:0], s0[15:0]};
      ed = {d1[15:0], d0[15:0]};
      c = c0 | c1;
    end else begin
      lane_ref(x, y, 32, s, es, ed, c);
    end
  endtask

  // drive at negedge, capture at posedge, check at following negedge
  task automatic run_op(input logic [31:0] x, input logic [31:0] y, input bit sp,
                        input bit s, input bit cl);
    logic [31:0] es, ed;
    bit c;
    string tag;
    model(x, y, sp, s, es, ed, c);
    exp_flag = (exp_flag & ~cl) | c;
    a = x; b = y; split = sp; sat = s; clr = cl;
    @(negedge clk);
    tag = sp ? (s ? "R5" : "R3") : (s ? "R4" : "R2");
    check({tag, " sum"}, sum, es);
    check({tag, " diff"}, diff, ed);
    check(cl ? "R7 flag" : "R6 flag", {31'd0, flag}, {31'd0, exp_flag});
  endtask

  logic [15:0] c16 [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                           16'hFFFF, 16'h7FFE, 16'h8001, 16'h1234};
  logic [31:0] c32 [10] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF,
                            32'h7FFFFFFE, 32'h80000001, 32'h12345678,
                            32'h00008000, 32'h0000FFFF};

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 sum", sum, 32'h0);
    check("R8 diff", diff, 32'h0);
    check("R8 flag", {31'd0, flag}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 latency: output unchanged before the edge, updated after
    a = 32'h00000005; b = 32'h00000003; split = 1'b0; sat = 1'b0;
    #1;
    check("R1 pre-edge sum", sum, 32'h0);
    @(negedge clk);
    check("R1 sum", sum, 32'h00000008);
    check("R1 diff", diff, 32'h00000002);

    // full-word sweeps, wrap and saturate; flag cleared between saturating runs
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run_op(c32[i], c32[j], 1'b0, s[0], 1'b1);

    // split-lane sweeps
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int k = 0; k < 8; k++)
            for (int l = 0; l < 8; l++)
              run_op({c16[i], c16[j]}, {c16[k], c16[l]}, 1'b1, s[0], 1'b0);

    // R2: carry across bit 16 in full mode
    run_op(32'h0000FFFF, 32'h00000001, 1'b0, 1'b0, 1'b1);
    check("R2 carry", sum, 32'h00010000);
    // R3: no carry across bit 16 in split mode
    run_op(32'h0000FFFF, 32'h00000001, 1'b1, 1'b0, 1'b0);
    check("R3 isolate", sum, 32'h00000000);
    // R5: one lane clamps, other exact
    run_op(32'h00017FFF, 32'h00020001, 1'b1, 1'b1, 1'b0);
    check("R5 mixed", sum, 32'h00037FFF);
    // R6: wrap overflow does not set flag
    run_op(32'h0, 32'h0, 1'b0, 1'b0, 1'b1);
    run_op(32'h7FFFFFFF, 32'h1, 1'b0, 1'b0, 1'b0);
    check("R6 no set on wrap", {31'd0, flag}, 32'h0);
    // R6: set then hold
    run_op(32'h7FFFFFFF, 32'h1, 1'b0, 1'b1, 1'b0);
    check("R6 set", {31'd0, flag}, 32'h1);
    run_op(32'h1, 32'h1, 1'b0, 1'b1, 1'b0);
    check("R6 hold", {31'd0, flag}, 32'h1);
    // R7: clear together with clamp keeps the flag
    run_op(32'h80000000, 32'h1, 1'b0, 1'b1, 1'b1);
    check("R7 clamp wins", {31'd0, flag}, 32'h1);
    // R7: clear without clamp
    run_op(32'h1, 32'h1, 1'b0, 1'b1, 1'b1);
    check("R7 cleared", {31'd0, flag}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule